// File: doc/BRIEF.md
# Serial Port FIFO Control and Flow-Control Gating

This block is the buffering and flag logic that sits between a processor bus and the serial shifter of a UART. It holds two 16-entry byte FIFOs: one the bus fills for transmission and the shifter drains, and one the shifter fills on reception and the bus drains. Each FIFO exposes its occupancy. A small control register selects the level at which the transmit side reports that it wants more data. It also enables or disables hardware flow control and can hold either FIFO empty.

The transmit status flag `tx_low` is high whenever the transmit occupancy is at or below the selected threshold. Software or an interrupt controller uses it to refill the FIFO in bursts. When flow control is enabled, the clear-to-send pin gates transmit draining, and the ready-to-send pin reflects how full the receive FIFO is. When flow control is disabled, clear-to-send is always treated as asserted and ready-to-send is held low.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, `reg_rdata` reads 0, both counts are 0 and `tx_low` is 1.
- R2: The transmit FIFO returns bytes in push order, its count never exceeds 16, and a push while it holds 16 bytes is ignored.
- R3: With trigger code T in control bits [1:0], the threshold is 8 when T=0, 4 when T=1, 2 when T=2 and 1 when T=3. `tx_low` is 1 exactly when `tx_count` is at or below that threshold, and it reflects the count registered at the last clock edge.
- R4: While control bit 3 is 1, the transmit count is forced to 0 from the next cycle on and pushes are ignored.
- R5: While control bit 4 is 1, the receive count is forced to 0 from the next cycle on and pushes are ignored.
- R6: While control bit 2 is 0, `cts_ok` is 1 whatever `cts_n_pin` is, and `rts_n` is 0.
- R7: While control bit 2 is 1, `cts_ok` is the inverse of `cts_n_pin`, a transmit pop is ignored while `cts_ok` is 0, and `rts_n` is 1 exactly when `rx_count` is 15 or more.
- R8: The receive FIFO returns bytes in push order. While it is empty, `rx_rdata` is 0 and a pop leaves the count at 0.
- R9: A cycle with `man_rst` high clears the control register and empties both FIFOs at that edge.
- R10: `reg_rdata` returns the control fields at bits [4:0] and reads 0 in bits [7:5]. A pop on an empty transmit FIFO leaves its count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| man_rst | input | 1 | Synchronous manual reset, active high |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| tx_push | input | 1 | Bus push into transmit FIFO |
| tx_wdata | input | 8 | Byte to push into transmit FIFO |
| tx_pop | input | 1 | Shifter pop from transmit FIFO |
| tx_rdata | output | 8 | Head of transmit FIFO (0 when empty) |
| tx_count | output | 5 | Transmit occupancy |
| tx_low | output | 1 | Transmit occupancy at or below threshold |
| rx_push | input | 1 | Shifter push into receive FIFO |
| rx_wdata | input | 8 | Received byte to push |
| rx_pop | input | 1 | Bus pop from receive FIFO |
| rx_rdata | output | 8 | Head of receive FIFO (0 when empty) |
| rx_count | output | 5 | Receive occupancy |
| cts_n_pin | input | 1 | Clear-to-send pin, active low |
| cts_ok | output | 1 | Effective clear-to-send, active high |
| rts_n | output | 1 | Ready-to-send pin, active low |

## Verification
A corrupted occupancy count shows at the ports on the next cycle. `tx_low` would toggle at the wrong fill level during a full sweep from 0 to 16 and back. `rx_rdata` or `tx_rdata` would also return a byte out of sequence or a stale byte from an empty FIFO. A wrong pointer shows within one FIFO pass as a mismatched byte at the head. A control bit that latched wrongly shows at once on the readback, on the handshake pins, or as a count that fails to clear one cycle after the reset bit is written.

// File: rtl/uart_fifo_ctl_pkg.sv
package uart_fifo_ctl_pkg;
  localparam int unsigned CTRL_W = 8;

  // Field positions: [1:0] trigger, [2] flow enable, [3] tx hold-empty, [4] rx hold-empty
  typedef struct packed {
    logic       rx_clr;
    logic       tx_clr;
    logic       flow_en;
    logic [1:0] trig;
  } ctrl_t;

  localparam int unsigned CTRL_USED = $bits(ctrl_t);
endpackage

// File: rtl/uart_fifo_rst_sync.sv
module uart_fifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/uart_fifo_core.sv
module uart_fifo_core #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, empty, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  assign rdata = empty ? '0 : mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/uart_fifo_ctrl_regs.sv
module uart_fifo_ctrl_regs
  import uart_fifo_ctl_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned HALF = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              man_rst,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output ctrl_t             ctrl,
  input  logic [CW-1:0]     tx_count,
  input  logic [CW-1:0]     rx_count,
  input  logic              cts_n_pin,
  output logic              cts_ok,
  output logic              rts_n,
  output logic              tx_low
);
  ctrl_t         ctrl_q, ctrl_d;
  logic [CW-1:0] thresh;

  always_comb begin
    ctrl_d = ctrl_q;
    if (man_rst)     ctrl_d = '0;
    else if (reg_we) ctrl_d = ctrl_t'(reg_wdata[CTRL_USED-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl      = ctrl_q;
  assign reg_rdata = {{(CTRL_W - CTRL_USED){1'b0}}, ctrl_q};

  // halving ladder: code 0 -> DEPTH/2, each step halves
  assign thresh = CW'(HALF) >> ctrl_q.trig;
  assign tx_low = (tx_count <= thresh);

  assign cts_ok = !ctrl_q.flow_en || !cts_n_pin;
  assign rts_n  = ctrl_q.flow_en && (rx_count >= CW'(DEPTH - 1));
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_ctl_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              man_rst,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              tx_push,
  input  logic [W-1:0]      tx_wdata,
  input  logic              tx_pop,
  output logic [W-1:0]      tx_rdata,
  output logic [CW-1:0]     tx_count,
  output logic              tx_low,
  input  logic              rx_push,
  input  logic [W-1:0]      rx_wdata,
  input  logic              rx_pop,
  output logic [W-1:0]      rx_rdata,
  output logic [CW-1:0]     rx_count,
  input  logic              cts_n_pin,
  output logic              cts_ok,
  output logic              rts_n
);
  logic  rst_i_n;
  ctrl_t ctrl;
  logic  tx_clr, rx_clr, tx_pop_g;

  uart_fifo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  uart_fifo_ctrl_regs #(.DEPTH(DEPTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .man_rst   (man_rst),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctrl      (ctrl),
    .tx_count  (tx_count),
    .rx_count  (rx_count),
    .cts_n_pin (cts_n_pin),
    .cts_ok    (cts_ok),
    .rts_n     (rts_n),
    .tx_low    (tx_low)
  );

  assign tx_clr   = man_rst || ctrl.tx_clr;
  assign rx_clr   = man_rst || ctrl.rx_clr;
  assign tx_pop_g = tx_pop && cts_ok;

  uart_fifo_core #(.DEPTH(DEPTH), .W(W)) u_txf (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (tx_clr),
    .push  (tx_push),
    .wdata (tx_wdata),
    .pop   (tx_pop_g),
    .rdata (tx_rdata),
    .count (tx_count)
  );

  uart_fifo_core #(.DEPTH(DEPTH), .W(W)) u_rxf (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (rx_clr),
    .push  (rx_push),
    .wdata (rx_wdata),
    .pop   (rx_pop),
    .rdata (rx_rdata),
    .count (rx_count)
  );
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          man_rst,
  input logic [7:0]    reg_rdata,
  input logic [CW-1:0] tx_count,
  input logic          tx_low,
  input logic [CW-1:0] rx_count,
  input logic [W-1:0]  rx_rdata,
  input logic          cts_n_pin,
  input logic          cts_ok,
  input logic          rts_n
);
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_rst && !reg_rdata[3]) |=>
      ((tx_count == $past(tx_count)) || (tx_count == $past(tx_count) + 1'b1) ||
       (tx_count + 1'b1 == $past(tx_count))));

  a_r3_empty_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |-> tx_low);

  a_r3_above_half: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count > CW'(DEPTH / 2)) |-> !tx_low);

  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[3] |=> (tx_count == '0));

  a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] |=> (rx_count == '0));

  a_r6_flow_off: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[2] |-> (cts_ok && !rts_n));

  a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[2] && cts_n_pin && !reg_rdata[3] && !man_rst) |=>
      (tx_count >= $past(tx_count)));

  a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> (rx_rdata == '0));

  a_r9_manual: assert property (@(posedge clk) disable iff (!rst_n)
    man_rst |=> ((tx_count == '0) && (rx_count == '0) && (reg_rdata == '0)));
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH), .W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .man_rst   (man_rst),
  .reg_rdata (reg_rdata),
  .tx_count  (tx_count),
  .tx_low    (tx_low),
  .rx_count  (rx_count),
  .rx_rdata  (rx_rdata),
  .cts_n_pin (cts_n_pin),
  .cts_ok    (cts_ok),
  .rts_n     (rts_n)
);

// File: tb/uart_fifo_ctl_tb.sv
module uart_fifo_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, man_rst, reg_we, tx_push, tx_pop, rx_push, rx_pop, cts_n_pin;
  logic [7:0] reg_wdata, reg_rdata, tx_wdata, tx_rdata, rx_wdata, rx_rdata;
  logic [4:0] tx_count, rx_count;
  logic       tx_low, cts_ok, rts_n;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  uart_fifo_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .man_rst(man_rst),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_low(tx_low),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .rx_count(rx_count),
    .cts_n_pin(cts_n_pin), .cts_ok(cts_ok), .rts_n(rts_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v; tick(); reg_we = 1'b0;
  endtask

  task automatic txw(input logic [7:0] d);
    tx_push = 1'b1; tx_wdata = d; tick(); tx_push = 1'b0;
  endtask

  task automatic txr();
    tx_pop = 1'b1; tick(); tx_pop = 1'b0;
  endtask

  task automatic rxw(input logic [7:0] d);
    rx_push = 1'b1; rx_wdata = d; tick(); rx_push = 1'b0;
  endtask

  task automatic rxr();
    rx_pop = 1'b1; tick(); rx_pop = 1'b0;
  endtask

  function automatic int thr(input int t);
    return 8 >> t;
  endfunction

  initial begin
    rst_n = 1'b0; man_rst = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    tx_push = 1'b0; tx_pop = 1'b0; tx_wdata = '0;
    rx_push = 1'b0; rx_pop = 1'b0; rx_wdata = '0; cts_n_pin = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state, R6 flow off by default
    chk("R1 ctrl", reg_rdata, 0);
    chk("R1 txcnt", tx_count, 0);
    chk("R1 rxcnt", rx_count, 0);
    chk("R1 txlow", tx_low, 1);
    chk("R6 cts_ok pin high", cts_ok, 1);
    chk("R6 rts_n", rts_n, 0);

    // R10 field readback
    wr_ctrl(8'hE6); chk("R10 readback", reg_rdata, 8'h06);
    wr_ctrl(8'h00); chk("R10 readback zero", reg_rdata, 0);
    txr(); chk("R10 tx pop empty", tx_count, 0);

    // R2/R3 sweep of every trigger code over every fill level
    for (int t = 0; t < 4; t++) begin
      wr_ctrl(8'(t));
      for (int i = 0; i < 17; i++) begin
        txw(8'(t * 32 + i));
        chk("R2 fill count", tx_count, (i < 16) ? i + 1 : 16);
        chk("R3 fill low", tx_low, (((i < 16) ? i + 1 : 16) <= thr(t)) ? 1 : 0);
      end
      for (int i = 0; i < 16; i++) begin
        chk("R2 head order", tx_rdata, t * 32 + i);
        txr();
        chk("R2 drain count", tx_count, 15 - i);
        chk("R3 drain low", tx_low, ((15 - i) <= thr(t)) ? 1 : 0);
      end
    end

    // R4 transmit hold-empty
    wr_ctrl(8'h00);
    for (int i = 0; i < 5; i++) txw(8'(i));
    wr_ctrl(8'h08);
    tick();
    chk("R4 cleared", tx_count, 0);
    txw(8'hAA);
    chk("R4 push ignored", tx_count, 0);
    wr_ctrl(8'h00);
    txw(8'h5C);
    chk("R4 after release count", tx_count, 1);
    chk("R4 after release data", tx_rdata, 8'h5C);
    txr();

    // R8 receive ordering and empty pop
    for (int i = 0; i < 3; i++) rxw(8'(8'h40 + i));
    for (int i = 0; i < 3; i++) begin
      chk("R8 rx order", rx_rdata, 8'h40 + i);
      rxr();
    end
    chk("R8 empty data", rx_rdata, 0);
    rxr();
    chk("R8 empty pop count", rx_count, 0);
    chk("R8 empty pop data", rx_rdata, 0);

    // R6 flow off with nearly full receive FIFO and pin high
    for (int i = 0; i < 15; i++) rxw(8'(i));
    chk("R6 rts_n off at 15", rts_n, 0);
    chk("R6 cts_ok off", cts_ok, 1);

    // R7 flow on
    wr_ctrl(8'h04);
    chk("R7 rts_n at 15", rts_n, 1);
    rxr();
    chk("R7 rts_n at 14", rts_n, 0);
    cts_n_pin = 1'b1;
    txw(8'h11);
    chk("R7 cts_ok pin high", cts_ok, 0);
    txr();
    chk("R7 pop blocked", tx_count, 1);
    cts_n_pin = 1'b0;
    #1 chk("R7 cts_ok pin low", cts_ok, 1);
    txr();
    chk("R7 pop allowed", tx_count, 0);

    // R5 receive hold-empty
    wr_ctrl(8'h14);
    tick();
    chk("R5 cleared", rx_count, 0);
    rxw(8'h33);
    chk("R5 push ignored", rx_count, 0);
    wr_ctrl(8'h00);

    // R9 manual reset
    for (int i = 0; i < 4; i++) begin txw(8'(i)); rxw(8'(i)); end
    wr_ctrl(8'h07);
    man_rst = 1'b1; tick(); man_rst = 1'b0;
    chk("R9 txcnt", tx_count, 0);
    chk("R9 rxcnt", rx_count, 0);
    chk("R9 ctrl", reg_rdata, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule